// File: doc/BRIEF.md
# Sector Hamming Check-Code Corrector

This block takes the parity word that a Hamming parity engine produced while a 512-byte sector streamed past, turns it into a 24-bit check code, and compares that code with the code stored next to the sector. The XOR of the two codes is the syndrome, and one strobe classifies it into one of four outcomes. The sector may be clean. It may hold a single flipped data bit, whose byte and bit position are reported. One bit of the stored code may itself be damaged. Or the damage may be beyond repair.

When the syndrome points at a data bit inside the sector, the block repairs the sector buffer without outside help. It reads the addressed byte through a byte-wide port with one cycle of read latency, flips the bit, writes the byte back, and then signals completion. For the other outcomes, completion is signalled together with the result and the buffer is left alone. The code is formed inverted, so an erased sector (all ones) read with an all-ones stored code is treated as clean.

Top module: `hecc_fix`

## Requirements
- R1: The fresh code is the bitwise inverse of {raw_word[27:16], raw_word[11:0]}. All other raw_word bits have no effect, so raw_word of zero gives 24'hFFFFFF.
- R2: stored_code carries the three stored code bytes with the least significant byte in bits 7:0 and the most significant in bits 23:16.
- R3: A zero syndrome (fresh XOR stored) gives status 0 (clean). done is raised in the same cycle as result_valid, and no buffer access is made.
- R4: When syndrome[23:12] XOR syndrome[11:0] equals 12'hFFF, the error is a data-bit error. byte_off is syndrome[23:15], bit_idx is syndrome[14:12], and status is 1 (data fixed).
- R5: A data-bit error whose byte_off is not below SECTOR_BYTES gives status 3 (uncorrectable).
- R6: A syndrome with exactly one bit set, when R4 does not apply, gives status 2 (code fixed). The buffer is not written and done rises with result_valid.
- R7: Every other non-zero syndrome gives status 3 (uncorrectable) and no buffer access.
- R8: result_valid is a one-cycle pulse in the cycle after the clock edge that accepts start. status, byte_off and bit_idx hold that result until the next accepted start.
- R9: With status 1, buf_rd_en is high with buf_addr = byte_off in the cycle of result_valid. In the next cycle buf_wr_en is high at the same address with buf_wdata = buf_rdata XOR (1 << bit_idx). done pulses in the cycle after the write.
- R10: A start seen while a buffer repair is in progress is ignored and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Compare strobe, one cycle |
| raw_word | input | 32 | Parity engine word for the sector just read |
| stored_code | input | 24 | Stored check code, byte 0 in bits 7:0 |
| result_valid | output | 1 | Result pulse |
| status | output | 2 | 0 clean, 1 data fixed, 2 code fixed, 3 uncorrectable |
| byte_off | output | 9 | Byte offset of the flipped data bit |
| bit_idx | output | 3 | Bit index within that byte |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_rd_en | output | 1 | Buffer read request, data returned next cycle |
| buf_rdata | input | 8 | Buffer read data |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Corrected byte |
| done | output | 1 | Operation complete pulse |

## Verification
The classification is due exactly one cycle after the accepting edge. At that point the driver also checks whether done has risen or a buffer read has started, depending on the expected outcome. For a data-bit error, the write is expected one cycle later, carrying the mask applied to the byte the bench memory returned. done and the updated memory byte are expected one cycle after that, three cycles after start in total. Each of these is sampled on the falling edge of its own cycle. A second start is placed in the read cycle of a repair, and the cycle in which its result would otherwise appear must show no result pulse.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

  localparam int HALF_W = 12;
  localparam int CODE_W = 2 * HALF_W;
  localparam int RAW_W  = 32;
  localparam int RAW_HI = 16;
  localparam int BIT_W  = 3;
  localparam int BYTE_W = 1 << BIT_W;
  localparam int OFF_W  = CODE_W - HALF_W - BIT_W;

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'd0,
    ST_DATA_FIX = 2'd1,
    ST_CODE_FIX = 2'd2,
    ST_BAD      = 2'd3
  } fix_status_e;

  typedef enum logic [1:0] {
    RMW_IDLE  = 2'd0,
    RMW_READ  = 2'd1,
    RMW_WRITE = 2'd2
  } rmw_state_e;

  typedef struct packed {
    fix_status_e             st;
    logic [OFF_W-1:0]        off;
    logic [BIT_W-1:0]        bix;
  } fix_result_t;

  // Two parity halves, upper above lower, inverted so erased pages check clean.
  function automatic logic [CODE_W-1:0] fold_raw(input logic [RAW_W-1:0] raw);
    return ~{raw[RAW_HI +: HALF_W], raw[0 +: HALF_W]};
  endfunction

  function automatic logic halves_complement(input logic [CODE_W-1:0] d);
    return (d[CODE_W-1:HALF_W] ^ d[HALF_W-1:0]) == {HALF_W{1'b1}};
  endfunction

  function automatic logic single_bit(input logic [CODE_W-1:0] d);
    return (d != '0) && ((d & (d - 1'b1)) == '0);
  endfunction

  function automatic logic [OFF_W-1:0] syn_offset(input logic [CODE_W-1:0] d);
    return d[CODE_W-1 -: OFF_W];
  endfunction

  function automatic logic [BIT_W-1:0] syn_bit(input logic [CODE_W-1:0] d);
    return d[HALF_W +: BIT_W];
  endfunction

  function automatic logic [BYTE_W-1:0] bit_mask(input logic [BIT_W-1:0] idx);
    return BYTE_W'(1) << idx;
  endfunction

endpackage

// File: rtl/hecc_diff.sv
module hecc_diff
  import hecc_pkg::*;
(
  input  logic [RAW_W-1:0]  raw_word,
  input  logic [CODE_W-1:0] stored_code,
  output logic [CODE_W-1:0] syndrome
);

  logic [CODE_W-1:0] fresh_code;

  assign fresh_code = fold_raw(raw_word);
  assign syndrome   = fresh_code ^ stored_code;

endmodule

// File: rtl/hecc_classify.sv
module hecc_classify
  import hecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic [CODE_W-1:0] syndrome,
  output fix_result_t       verdict
);

  logic is_zero, is_pair, is_lone, in_range;

  assign is_zero  = (syndrome == '0);
  assign is_pair  = halves_complement(syndrome);
  assign is_lone  = single_bit(syndrome);
  assign in_range = int'(syn_offset(syndrome)) < SECTOR_BYTES;

  always_comb begin
    verdict.st  = ST_CLEAN;
    verdict.off = '0;
    verdict.bix = '0;
    if (!is_zero) begin
      if (is_pair) begin
        if (in_range) begin
          verdict.st  = ST_DATA_FIX;
          verdict.off = syn_offset(syndrome);
          verdict.bix = syn_bit(syndrome);
        end else begin
          verdict.st = ST_BAD;
        end
      end else if (is_lone) begin
        verdict.st = ST_CODE_FIX;
      end else begin
        verdict.st = ST_BAD;
      end
    end
  end

endmodule

// File: rtl/hecc_rmw.sv
module hecc_rmw
  import hecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [OFF_W-1:0]  go_addr,
  input  logic [BIT_W-1:0]  go_bix,
  input  logic [BYTE_W-1:0] rdata,
  output logic              busy,
  output logic              rd_en,
  output logic              wr_en,
  output logic [OFF_W-1:0]  addr,
  output logic [BYTE_W-1:0] wdata,
  output logic              fixed
);

  rmw_state_e       state_q;
  logic [OFF_W-1:0] addr_q;
  logic [BIT_W-1:0] bix_q;
  logic             fixed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RMW_IDLE;
      addr_q  <= '0;
      bix_q   <= '0;
      fixed_q <= 1'b0;
    end else begin
      fixed_q <= 1'b0;
      case (state_q)
        RMW_IDLE: begin
          if (go) begin
            addr_q  <= go_addr;
            bix_q   <= go_bix;
            state_q <= RMW_READ;
          end
        end
        RMW_READ:  state_q <= RMW_WRITE;
        RMW_WRITE: begin
          state_q <= RMW_IDLE;
          fixed_q <= 1'b1;
        end
        default:   state_q <= RMW_IDLE;
      endcase
    end
  end

  assign busy  = (state_q != RMW_IDLE);
  assign rd_en = (state_q == RMW_READ);
  assign wr_en = (state_q == RMW_WRITE);
  assign addr  = addr_q;
  assign wdata = rdata ^ bit_mask(bix_q);
  assign fixed = fixed_q;

endmodule

// File: rtl/hecc_fix.sv
module hecc_fix
  import hecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RAW_W-1:0]  raw_word,
  input  logic [CODE_W-1:0] stored_code,
  output logic              result_valid,
  output logic [1:0]        status,
  output logic [OFF_W-1:0]  byte_off,
  output logic [BIT_W-1:0]  bit_idx,
  output logic [OFF_W-1:0]  buf_addr,
  output logic              buf_rd_en,
  input  logic [BYTE_W-1:0] buf_rdata,
  output logic              buf_wr_en,
  output logic [BYTE_W-1:0] buf_wdata,
  output logic              done
);

  logic [CODE_W-1:0] syndrome;
  fix_result_t       verdict;
  logic              fix_busy;
  logic              accept;
  logic              data_go;
  logic              rmw_fixed;

  logic              valid_q;
  fix_status_e       status_q;
  logic [OFF_W-1:0]  off_q;
  logic [BIT_W-1:0]  bix_q;
  logic              quick_done_q;

  hecc_diff u_diff (
    .raw_word    (raw_word),
    .stored_code (stored_code),
    .syndrome    (syndrome)
  );

  hecc_classify #(.SECTOR_BYTES(SECTOR_BYTES)) u_cls (
    .syndrome (syndrome),
    .verdict  (verdict)
  );

  assign accept  = start & ~fix_busy;
  assign data_go = accept & (verdict.st == ST_DATA_FIX);

  hecc_rmw u_rmw (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (data_go),
    .go_addr (verdict.off),
    .go_bix  (verdict.bix),
    .rdata   (buf_rdata),
    .busy    (fix_busy),
    .rd_en   (buf_rd_en),
    .wr_en   (buf_wr_en),
    .addr    (buf_addr),
    .wdata   (buf_wdata),
    .fixed   (rmw_fixed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q      <= 1'b0;
      status_q     <= ST_CLEAN;
      off_q        <= '0;
      bix_q        <= '0;
      quick_done_q <= 1'b0;
    end else begin
      valid_q      <= accept;
      quick_done_q <= accept & (verdict.st != ST_DATA_FIX);
      if (accept) begin
        status_q <= verdict.st;
        off_q    <= verdict.off;
        bix_q    <= verdict.bix;
      end
    end
  end

  assign result_valid = valid_q;
  assign status       = status_q;
  assign byte_off     = off_q;
  assign bit_idx      = bix_q;
  assign done         = quick_done_q | rmw_fixed;

endmodule

// File: rtl/hecc_fix_chk.sv
module hecc_fix_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       result_valid,
  input logic [1:0] status,
  input logic       buf_rd_en,
  input logic       buf_wr_en,
  input logic [8:0] buf_addr,
  input logic       done
);

  p_valid_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> result_valid);

  p_no_result_when_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && !busy) |=> !result_valid);

  p_read_on_data_fix_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && status == 2'd1) |-> buf_rd_en);

  p_write_follows_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_en |=> (buf_wr_en && $stable(buf_addr)));

  p_done_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |=> done);

  p_quiet_buffer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && status != 2'd1) |-> (done && !buf_rd_en && !buf_wr_en));

  p_rd_wr_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_rd_en && buf_wr_en));

endmodule

bind hecc_fix hecc_fix_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .busy         (fix_busy),
  .result_valid (result_valid),
  .status       (status),
  .buf_rd_en    (buf_rd_en),
  .buf_wr_en    (buf_wr_en),
  .buf_addr     (buf_addr),
  .done         (done)
);

// File: tb/sim_hecc_fix.sv
module sim_hecc_fix;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, start;
  logic [31:0] raw_word;
  logic [23:0] stored_code;
  logic        result_valid, buf_rd_en, buf_wr_en, done;
  logic [1:0]  status;
  logic [8:0]  byte_off, buf_addr;
  logic [2:0]  bit_idx;
  logic [7:0]  buf_rdata, buf_wdata;

  logic        start1;
  logic [23:0] stored1;
  logic        rv1, rd1, wr1, done1;
  logic [1:0]  st1;
  logic [8:0]  off1, addr1;
  logic [2:0]  bix1;
  logic [7:0]  wd1;

  hecc_fix u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .raw_word(raw_word),
    .stored_code(stored_code), .result_valid(result_valid), .status(status),
    .byte_off(byte_off), .bit_idx(bit_idx), .buf_addr(buf_addr),
    .buf_rd_en(buf_rd_en), .buf_rdata(buf_rdata), .buf_wr_en(buf_wr_en),
    .buf_wdata(buf_wdata), .done(done)
  );

  hecc_fix #(.SECTOR_BYTES(256)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start1), .raw_word(32'h0),
    .stored_code(stored1), .result_valid(rv1), .status(st1),
    .byte_off(off1), .bit_idx(bix1), .buf_addr(addr1),
    .buf_rd_en(rd1), .buf_rdata(8'h00), .buf_wr_en(wr1),
    .buf_wdata(wd1), .done(done1)
  );

  logic [7:0] mem [512];
  int wr_count = 0;
  int wr_expect = 0;

  always @(posedge clk) begin
    if (buf_rd_en) buf_rdata <= mem[buf_addr];
    if (buf_wr_en) begin
      mem[buf_addr] <= buf_wdata;
      wr_count++;
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  typedef struct {
    logic [1:0] st;
    logic [8:0] off;
    logic [2:0] bi;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t got_e;

  // Bench view of the fresh code: halves concatenated, then flipped.
  function automatic logic [23:0] calc_of(input logic [31:0] raw);
    return {raw[27:16], raw[11:0]} ^ 24'hFFFFFF;
  endfunction

  function automatic exp_t predict(input logic [23:0] d, input int sector, input string tag);
    exp_t e;
    logic [11:0] lo, hi;
    e.st = 2'd0; e.off = '0; e.bi = '0; e.tag = tag;
    lo = d[11:0];
    hi = d[23:12];
    if (d == 24'h0) e.st = 2'd0;
    else if ((hi | lo) == 12'hFFF && (hi & lo) == 12'h000) begin
      if (int'(d >> 15) < sector) begin
        e.st = 2'd1; e.off = 9'(d >> 15); e.bi = 3'((d >> 12) & 24'h7);
      end else e.st = 2'd3;
    end else if ($countones(d) == 1) e.st = 2'd2;
    else e.st = 2'd3;
    return e;
  endfunction

  function automatic logic [23:0] data_syn(input int off, input int b);
    logic [11:0] ob;
    ob = 12'(off * 8 + b);
    return {ob, ~ob};
  endfunction

  // Monitor: pops one expected item for every result pulse.
  always @(negedge clk) begin
    if (rst_n && result_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R10", "unexpected result", 1, 0);
      else begin
        got_e = exp_q.pop_front();
        chk(status == got_e.st, got_e.tag, "status", int'(status), int'(got_e.st));
        if (got_e.st == 2'd1) begin
          chk(byte_off == got_e.off, got_e.tag, "byte_off", int'(byte_off), int'(got_e.off));
          chk(bit_idx == got_e.bi, got_e.tag, "bit_idx", int'(bit_idx), int'(got_e.bi));
        end
      end
    end
  end

  // Driver: called at a falling edge, returns at a falling edge.
  task automatic send(input logic [31:0] raw, input logic [23:0] stored,
                      input string tag, input bit probe_busy);
    exp_t e;
    logic [7:0] old, mask;
    e = predict(calc_of(raw) ^ stored, 512, tag);
    old = mem[e.off];
    mask = 8'(1) << e.bi;
    raw_word = raw; stored_code = stored; start = 1'b1;
    exp_q.push_back(e);
    @(negedge clk);
    start = 1'b0;
    chk(result_valid == 1'b1, "R8", "result_valid", int'(result_valid), 1);
    if (e.st != 2'd1) begin
      chk(done == 1'b1 && buf_rd_en == 1'b0, tag, "done without buffer access",
          int'({done, buf_rd_en}), 2);
    end else begin
      wr_expect++;
      chk(buf_rd_en == 1'b1 && buf_addr == e.off, "R9", "read address",
          int'(buf_addr), int'(e.off));
      if (probe_busy) begin
        raw_word = 32'h0; stored_code = 24'hFFFFFF; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      if (probe_busy) chk(result_valid == 1'b0, "R10", "result while busy", int'(result_valid), 0);
      chk(buf_wr_en == 1'b1 && buf_wdata == (old ^ mask), "R9", "write data",
          int'(buf_wdata), int'(old ^ mask));
      chk(done == 1'b0, "R9", "done early", int'(done), 0);
      @(negedge clk);
      chk(done == 1'b1, "R9", "done after write", int'(done), 1);
      chk(mem[e.off] == (old ^ mask), "R4", "buffer byte", int'(mem[e.off]), int'(old ^ mask));
      if (probe_busy) chk(result_valid == 1'b0, "R10", "late result", int'(result_valid), 0);
    end
    @(negedge clk);
  endtask

  task automatic send_small(input logic [23:0] d, input logic [1:0] want, input string tag);
    stored1 = 24'hFFFFFF ^ d; start1 = 1'b1;
    @(negedge clk);
    start1 = 1'b0;
    chk(rv1 == 1'b1 && st1 == want, tag, "small sector status", int'(st1), int'(want));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 37 + 11);
    rst_n = 1'b0; start = 1'b0; start1 = 1'b0;
    raw_word = '0; stored_code = '0; stored1 = '0;
    repeat (3) @(negedge clk);
    chk(result_valid == 1'b0 && done == 1'b0 && status == 2'd0, "R8", "reset outputs",
        int'({result_valid, done, status}), 0);
    chk(buf_rd_en == 1'b0 && buf_wr_en == 1'b0, "R9", "reset buffer strobes",
        int'({buf_rd_en, buf_wr_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: erased sector, and raw bits outside the two halves have no effect
    send(32'h0000_0000, 24'hFFFFFF, "R1", 1'b0);
    send(32'hF000_F000, 24'hFFFFFF, "R1", 1'b0);
    // R2/R3: byte 0 in the low bits; a swapped order would not check clean
    send(32'h0ABC_0123, {8'h54, 8'h3E, 8'hDC}, "R2", 1'b0);
    send(32'h0ABC_0123, {8'hDC, 8'h3E, 8'h54}, "R7", 1'b0);
    send(32'h0555_0AAA, calc_of(32'h0555_0AAA), "R3", 1'b0);

    // R4/R9: data-bit repairs, including both ends of the sector
    send(32'h0123_0456, calc_of(32'h0123_0456) ^ data_syn(5, 3), "R4", 1'b0);
    send(32'h0000_0000, 24'hFFFFFF ^ data_syn(511, 7), "R4", 1'b0);
    send(32'h0FFF_0FFF, calc_of(32'h0FFF_0FFF) ^ data_syn(0, 0), "R4", 1'b0);
    chk(mem[4] == 8'(4 * 37 + 11) && mem[6] == 8'(6 * 37 + 11), "R9", "neighbours intact",
        int'(mem[4]), int'(8'(4 * 37 + 11)));

    // R6: lone bit in the code
    send(32'h0000_0000, 24'hFFFFFF ^ 24'h020000, "R6", 1'b0);
    send(32'h0000_0000, 24'hFFFFFF ^ 24'h000001, "R6", 1'b0);
    send(32'h0000_0000, 24'hFFFFFF ^ 24'h800000, "R6", 1'b0);

    // R7: other patterns
    send(32'h0000_0000, 24'hFFFFFF ^ 24'h000003, "R7", 1'b0);
    send(32'h0000_0000, 24'hFFFFFF ^ 24'h00F00F, "R7", 1'b0);
    send(32'h0000_0000, 24'h000000, "R7", 1'b0);

    // R10: a start during a repair is dropped
    send(32'h0000_0000, 24'hFFFFFF ^ data_syn(200, 5), "R10", 1'b1);

    // R5: offset past a 256-byte sector
    send_small(data_syn(300, 2), 2'd3, "R5");
    send_small(data_syn(100, 6), 2'd1, "R5");

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "results outstanding", exp_q.size(), 0);
    chk(wr_count == wr_expect, "R6", "buffer write count", wr_count, wr_expect);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule